// File: doc/BRIEF.md
# Countdown Timer with Register Interface

A 32-bit countdown timer that software drives through four word-sized registers on a simple single-cycle register bus. Software writes a load value, which also goes straight into the live counter. It then starts the counter with a strobe bit in the control word. The counter drops by one on every clock while it runs. When it reaches zero and one more clock passes, the block raises a sticky timeout flag. In one-shot mode the counter then halts. In auto-reload mode it picks up the load value again and keeps going.

A level interrupt output is the timeout flag gated by an enable bit. Software acknowledges the timeout by writing any value to the status register. A read-only register shows the live count at any moment. Read data is combinational from the block's registers. A write takes effect on the clock edge that samples it.

Top module: `cdt_timer`

## Requirements
- R1: Register map by byte address, word index = address bits [4:2], address bits [1:0] must be zero: 0x00 status (bit 0 timeout flag, bit 1 running), 0x04 control (bit 0 interrupt enable, bit 1 auto-reload; bits 2 and 3 are strobes that read back as 0), 0x08 load value, 0x0C live count. All other bits read 0. Any other address, including a misaligned one, reads 0.
- R2: After reset every register reads 0, the counter is halted and `irq` is low.
- R3: A write to 0x08 stores the value and places it in the live counter on the same edge, whether or not the counter is running. This overrides that cycle's decrement or reload.
- R4: While running, the live count falls by one per clock. Once it reads 0, the next edge sets the timeout flag, so a start with count N sets the flag N+1 edges after the start edge.
- R5: In one-shot mode (control bit 1 = 0), an expiry clears the running bit and the count stays at 0.
- R6: In auto-reload mode (control bit 1 = 1), an expiry reloads the count from the load register and the running bit stays 1.
- R7: A control write with bit 2 set starts the counter. A write with bit 3 set stops it, and bit 3 wins when both are set. A control write with neither bit leaves the running state unchanged.
- R8: Any write to 0x00 clears the timeout flag and changes nothing else. An expiry on the same edge wins, so the flag stays set.
- R9: `irq` is high exactly when the timeout flag and the interrupt-enable bit are both 1, and it follows every register write.
- R10: Writes to 0x0C, to unmapped addresses and to misaligned addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, 0 when no mapped read is active |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a status-register write that lands on the very edge where the counter expires. Only then does the rule that set beats clear show up. The bench reaches it by cycle counting. It starts an auto-reload run with a small load value, idles a known number of cycles, and issues the clearing write so that its sampling edge coincides with the expiry edge. It then reads the flag back.

A similar count places a stop strobe on the edge where an auto-reload counter sits at zero. This shows that the reload and the halt happen together.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // word indices of the register map
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_CTRL   = 1;
  localparam int unsigned IDX_LOAD   = 2;
  localparam int unsigned IDX_LIVE   = 3;
  localparam int unsigned NUM_REGS   = 4;

  // status bits
  localparam int unsigned ST_TO_BIT  = 0;
  localparam int unsigned ST_RUN_BIT = 1;

  // control bits
  localparam int unsigned CT_IEN_BIT   = 0;
  localparam int unsigned CT_AUTO_BIT  = 1;
  localparam int unsigned CT_START_BIT = 2;
  localparam int unsigned CT_STOP_BIT  = 3;
  localparam int unsigned CT_W         = 4;

  typedef struct packed {
    logic status;
    logic ctrl;
    logic load;
  } wr_strobe_t;
endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = 1'b1;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_s_n = sh_q[STAGES-1];
endmodule

// File: rtl/cdt_decode.sv
module cdt_decode
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              to_q,
  input  logic              run_q,
  input  logic              ien_q,
  input  logic              auto_q,
  input  logic [DATA_W-1:0] load_q,
  input  logic [DATA_W-1:0] cnt_q,
  output wr_strobe_t        wr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned SEL_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [DATA_W-1:0] rmap [NUM_REGS];

  assign idx = bus_addr[ADDR_W-1:2];
  assign hit = (bus_addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));

  always_comb begin
    wr = '0;
    if (bus_sel && bus_we && hit) begin
      wr.status = (idx == IDX_W'(IDX_STATUS));
      wr.ctrl   = (idx == IDX_W'(IDX_CTRL));
      wr.load   = (idx == IDX_W'(IDX_LOAD));
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) rmap[i] = '0;
    rmap[IDX_STATUS][ST_TO_BIT]  = to_q;
    rmap[IDX_STATUS][ST_RUN_BIT] = run_q;
    rmap[IDX_CTRL][CT_IEN_BIT]   = ien_q;
    rmap[IDX_CTRL][CT_AUTO_BIT]  = auto_q;
    rmap[IDX_LOAD]               = load_q;
    rmap[IDX_LIVE]               = cnt_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we && hit) bus_rdata = rmap[idx[SEL_W-1:0]];
  end
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_strobe_t        wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic              to_q,
  output logic              run_q,
  output logic              ien_q,
  output logic              auto_q,
  output logic [DATA_W-1:0] load_q
);
  logic start_s, stop_s;
  logic ctl_en, load_en, to_en, run_en;
  logic to_d, run_d;

  assign start_s = wr.ctrl && wdata[CT_START_BIT];
  assign stop_s  = wr.ctrl && wdata[CT_STOP_BIT];

  // next-state and enables
  always_comb begin
    ctl_en  = wr.ctrl;
    load_en = wr.load;
    to_en   = expire || wr.status;
    to_d    = expire;
    run_en  = start_s || stop_s || (expire && !auto_q);
    run_d   = start_s && !stop_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      auto_q <= 1'b0;
    end else if (ctl_en) begin
      ien_q  <= wdata[CT_IEN_BIT];
      auto_q <= wdata[CT_AUTO_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= '0;
    else if (load_en) load_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     to_q <= 1'b0;
    else if (to_en) to_q <= to_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_en) run_q <= run_d;
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_q,
  input  logic              auto_q,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              expire
);
  logic              zero;
  logic              cnt_en;
  logic [DATA_W-1:0] cnt_d;

  assign zero   = (cnt_q == '0);
  assign expire = run_q && zero;

  always_comb begin
    cnt_en = load || (run_q && (!zero || auto_q));
    if (load)      cnt_d = load_val;
    else if (zero) cnt_d = load_q;
    else           cnt_d = cnt_q - DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              rst_s_n;
  wr_strobe_t        wr;
  logic              to_q, run_q, ien_q, auto_q, expire;
  logic [DATA_W-1:0] load_q, cnt_q;

  cdt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  cdt_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .to_q(to_q), .run_q(run_q), .ien_q(ien_q), .auto_q(auto_q),
    .load_q(load_q), .cnt_q(cnt_q), .wr(wr), .bus_rdata(bus_rdata)
  );

  cdt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .wr(wr), .wdata(bus_wdata),
    .expire(expire), .to_q(to_q), .run_q(run_q), .ien_q(ien_q),
    .auto_q(auto_q), .load_q(load_q)
  );

  cdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .run_q(run_q), .auto_q(auto_q),
    .load(wr.load), .load_val(bus_wdata), .load_q(load_q),
    .cnt_q(cnt_q), .expire(expire)
  );

  assign irq = to_q && ien_q;
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_s_n,
  input wr_strobe_t        wr,
  input logic [DATA_W-1:0] wdata,
  input logic              expire,
  input logic              to_q,
  input logic              run_q,
  input logic              ien_q,
  input logic              auto_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] load_q,
  input logic              irq
);
  // R3
  load_now_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr.load |=> (cnt_q == $past(wdata)) && (load_q == $past(wdata)));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_q && cnt_q != '0 && !wr.load) |=> cnt_q == $past(cnt_q) - DATA_W'(1));

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    expire |=> to_q);

  // R5
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (expire && !auto_q && !wr.ctrl && !wr.load) |=> (!run_q && cnt_q == '0));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (expire && auto_q && !wr.load && !(wr.ctrl && wdata[CT_STOP_BIT]))
      |=> (run_q && cnt_q == $past(load_q)));

  // R7
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr.ctrl && wdata[CT_STOP_BIT]) |=> !run_q);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr.status && !expire) |=> !to_q);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> (to_q && ien_q));
endmodule

bind cdt_timer cdt_timer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_s_n(rst_s_n), .wr(wr), .wdata(bus_wdata),
  .expire(expire), .to_q(to_q), .run_q(run_q), .ien_q(ien_q),
  .auto_q(auto_q), .cnt_q(cnt_q), .load_q(load_q), .irq(irq)
);

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  typedef struct {
    logic [4:0]  addr;
    logic [31:0] data;
    logic        irq;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  cdt_timer #(.DATA_W(32), .ADDR_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e,
                    input logic ei, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
    it.addr = a; it.data = e; it.irq = ei; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
    end
  endtask

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_we) begin
      item_t it;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL monitor: read with no expected item, actual=%h expected=none", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        if (bus_rdata !== it.data || irq !== it.irq) begin
          errors++;
          $display("FAIL %s addr=%h actual data=%h irq=%b expected data=%h irq=%b",
                   it.tag, it.addr, bus_rdata, irq, it.data, it.irq);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    #22 rst_n = 1'b1;
    idle(4);

    // R2 reset state
    rd(5'h00, 32'd0, 1'b0, "R2 status");
    rd(5'h04, 32'd0, 1'b0, "R2 control");
    rd(5'h08, 32'd0, 1'b0, "R2 load");
    rd(5'h0C, 32'd0, 1'b0, "R2 live");

    // R1 / R10 unmapped and misaligned
    rd(5'h10, 32'd0, 1'b0, "R1 unmapped read");
    rd(5'h02, 32'd0, 1'b0, "R1 misaligned read");
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h09, 32'h0000_00FF);
    wr(5'h05, 32'h0000_0005);
    rd(5'h08, 32'd0, 1'b0, "R10 load untouched");
    rd(5'h04, 32'd0, 1'b0, "R10 control untouched");
    rd(5'h00, 32'd0, 1'b0, "R10 not started");

    // R3 load goes to live counter
    wr(5'h08, 32'd100);
    rd(5'h0C, 32'd100, 1'b0, "R3 live after load");
    rd(5'h08, 32'd100, 1'b0, "R3 load readback");

    // R4 R5 R9 one-shot with interrupt enabled
    wr(5'h08, 32'd3);
    wr(5'h04, 32'h5);
    rd(5'h0C, 32'd3, 1'b0, "R4 count 3");
    rd(5'h0C, 32'd2, 1'b0, "R4 count 2");
    rd(5'h0C, 32'd1, 1'b0, "R4 count 1");
    rd(5'h0C, 32'd0, 1'b0, "R4 count 0");
    rd(5'h00, 32'd1, 1'b1, "R5 expired one-shot, R9 irq");
    rd(5'h0C, 32'd0, 1'b1, "R5 count held at 0");
    rd(5'h04, 32'd1, 1'b1, "R1 strobes read 0");

    // R8 clear
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, 32'd0, 1'b0, "R8 flag cleared");
    rd(5'h04, 32'd1, 1'b0, "R8 control kept");
    rd(5'h08, 32'd3, 1'b0, "R8 load kept");

    // R6 auto-reload, irq disabled
    wr(5'h08, 32'd2);
    wr(5'h04, 32'h6);
    rd(5'h0C, 32'd2, 1'b0, "R6 count 2");
    rd(5'h0C, 32'd1, 1'b0, "R6 count 1");
    rd(5'h0C, 32'd0, 1'b0, "R6 count 0");
    rd(5'h00, 32'd3, 1'b0, "R6 reloaded and running, R9 gated");
    rd(5'h0C, 32'd1, 1'b0, "R6 counting after reload");
    // R7 stop on the zero edge: reload and halt together
    wr(5'h04, 32'h8);
    rd(5'h0C, 32'd2, 1'b0, "R7 halted");
    rd(5'h0C, 32'd2, 1'b0, "R7 still halted");
    rd(5'h00, 32'd1, 1'b0, "R7 running bit low");
    rd(5'h04, 32'd0, 1'b0, "R7 control after stop");

    // R9 enable follows write
    wr(5'h04, 32'h1);
    rd(5'h00, 32'd1, 1'b1, "R9 irq on enable, R7 run kept");
    wr(5'h04, 32'h0);
    rd(5'h00, 32'd1, 1'b0, "R9 irq off");

    // R7 start+stop together
    wr(5'h00, 32'd0);
    wr(5'h08, 32'd5);
    wr(5'h04, 32'hC);
    rd(5'h00, 32'd0, 1'b0, "R7 stop wins");
    rd(5'h0C, 32'd5, 1'b0, "R7 count unchanged");

    // R10 live register write ignored
    wr(5'h0C, 32'd77);
    rd(5'h0C, 32'd5, 1'b0, "R10 live write ignored");
    rd(5'h08, 32'd5, 1'b0, "R10 load unaffected");

    // R3 load while running
    wr(5'h04, 32'h4);
    wr(5'h08, 32'd50);
    rd(5'h0C, 32'd50, 1'b0, "R3 reload while running");
    rd(5'h0C, 32'd49, 1'b0, "R3 counting from new value");
    rd(5'h00, 32'd2, 1'b0, "R3 still running");
    wr(5'h04, 32'h8);

    // R4 longer count: N=20 expires 21 edges after start
    wr(5'h08, 32'd20);
    wr(5'h04, 32'h4);
    idle(20);
    rd(5'h00, 32'd2, 1'b0, "R4 no flag at count 0");
    rd(5'h00, 32'd1, 1'b0, "R4 flag at N+1");

    // R8 clear on the expiry edge loses
    wr(5'h00, 32'd0);
    wr(5'h08, 32'd2);
    wr(5'h04, 32'h6);
    idle(2);
    wr(5'h00, 32'd0);
    rd(5'h00, 32'd3, 1'b0, "R8 expiry beats clear");
    wr(5'h04, 32'h8);

    idle(3);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule